// File: doc/BRIEF.md
# Edge/Level Interrupt Request Latch

This block captures a bank of interrupt input lines into a request register. Each line is set to edge capture or level following by a bit in a mode register. Edge detection relies on a stored last-seen level for each line. Events reach the block one at a time. Each event is a strobe with a line index and the new level of that line. One cycle after each event, the block returns a two-bit delivery status: masked, coalesced or accepted.

The acknowledge logic clears a request through a one-cycle acknowledge strobe with a line index. Software writes the mode register through a fixed writable-bit mask, which is a parameter of each instance. A typical setup uses 8'hF8 for a primary bank and 8'hDE for a cascaded bank. An initialization pulse clears edge history and drops the pending edge requests. Priority resolution, the in-service state and the host register interface sit outside this block. The per-line mask vector arrives as an input.

Top module: `irq_req_latch`

## Requirements
- R1: After reset, `req_o`, `last_o` and `mode_o` are all zero and `stat_vld_o` is low.
- R2: A line whose mode bit is 1 (level) follows its input. An event with level 1 sets both its request bit and its last-level bit. An event with level 0 clears both.
- R3: A line whose mode bit is 0 (edge) sets its request bit on a level-1 event only when its last-level bit was 0. The event then sets the last-level bit.
- R4: On an edge-mode line, a level-0 event clears only the last-level bit. The request bit keeps its value.
- R5: The status for each event appears on `stat_code_o` with `stat_vld_o` high for exactly the cycle after the event. The code is 2'b11 when the line's `mask_i` bit is 1. Otherwise it is 2'b00 when the event would set a request bit that is already set, and 2'b01 for any other event.
- R6: A mode-register write stores `mode_wdata_i & MODE_WMASK` (default 8'hF8). Bits outside the mask stay 0.
- R7: An acknowledge clears the request bit of the indexed line only when that line is in edge mode. If an event and an acknowledge hit the same line in the same cycle, the acknowledge is applied first.
- R8: An initialization pulse clears every last-level bit and keeps only the request bits of level-mode lines. Events and acknowledges in that same cycle are ignored and produce no status.
- R9: A mode write takes effect the cycle after it. An event in the same cycle is handled with the old mode.
- R10: A masked event still updates the request and last-level bits by the same rules as an unmasked one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_vld_i | input | 1 | Input event strobe |
| evt_line_i | input | 3 | Line index of the event |
| evt_level_i | input | 1 | New level of the line |
| mask_i | input | 8 | Per-line mask bits used for status |
| ack_vld_i | input | 1 | Acknowledge strobe |
| ack_line_i | input | 3 | Line being acknowledged |
| mode_we_i | input | 1 | Mode register write enable |
| mode_wdata_i | input | 8 | Mode register write data |
| init_i | input | 1 | Initialization pulse |
| req_o | output | 8 | Request register |
| last_o | output | 8 | Last-seen level per line |
| mode_o | output | 8 | Mode register (1 = level) |
| stat_vld_o | output | 1 | Status valid, one cycle after an event |
| stat_code_o | output | 2 | 11 masked, 00 coalesced, 01 accepted |

## Verification
Every register sits directly on an output, so a wrong request, last-level or mode bit shows at the ports on the edge that wrote it. A corrupt last-level bit that is not yet visible as a difference in `req_o` shows there later. It appears as a missed or duplicated edge capture on the next level-1 event for that line, and the status code changes in the cycle after that event. The bench compares all outputs after every cycle against a model, so it catches such a divergence in the cycle where it appears.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
  typedef enum logic [1:0] {
    ST_COALESCED = 2'b00,
    ST_ACCEPTED  = 2'b01,
    ST_MASKED    = 2'b11
  } stat_code_e;
endpackage

// File: rtl/irq_index_dec.sv
module irq_index_dec #(
  parameter int N     = 8,
  localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic          en_i,
  input  logic [IW-1:0] idx_i,
  output logic [N-1:0]  hit_o
);
  for (genvar g = 0; g < N; g++) begin : g_dec
    assign hit_o[g] = en_i && (idx_i == IW'(g));
  end
endmodule

// File: rtl/irq_line_cell.sv
module irq_line_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_hit_i,
  input  logic level_i,
  input  logic mode_i,
  input  logic ack_hit_i,
  input  logic init_i,
  output logic req_o,
  output logic last_o,
  output logic coal_o
);
  logic req_q, last_q;
  logic req_ack, try_set;

  assign req_ack = req_q & ~(ack_hit_i & ~mode_i);
  assign try_set = evt_hit_i & level_i & (mode_i | ~last_q);
  assign coal_o  = try_set & req_ack;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      last_q <= 1'b0;
    end else if (init_i) begin
      last_q <= 1'b0;
      req_q  <= req_q & mode_i;
    end else begin
      req_q <= req_ack;
      if (evt_hit_i) begin
        last_q <= level_i;
        if (mode_i)       req_q <= level_i;
        else if (try_set) req_q <= 1'b1;
      end
    end
  end

  assign req_o  = req_q;
  assign last_o = last_q;

  a_r2_level_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_hit_i && mode_i && !init_i) |=> (req_q == $past(level_i)));
  a_r4_edge_low_keeps_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_hit_i && !mode_i && !level_i && !init_i && !ack_hit_i) |=> $stable(req_q));
  a_r8_init_clears_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> !last_q);
  a_r7_ack_edge_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_hit_i && !mode_i && !evt_hit_i && !init_i) |=> !req_q);
endmodule

// File: rtl/irq_stat_gen.sv
module irq_stat_gen
  import irq_latch_pkg::*;
#(
  parameter int N     = 8,
  localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          evt_vld_i,
  input  logic [IW-1:0] evt_line_i,
  input  logic          init_i,
  input  logic [N-1:0]  mask_i,
  input  logic [N-1:0]  coal_i,
  output logic          stat_vld_o,
  output stat_code_e    stat_code_o
);
  logic       fire;
  stat_code_e code_d;

  assign fire = evt_vld_i & ~init_i;

  always_comb begin
    if (mask_i[evt_line_i])      code_d = ST_MASKED;
    else if (coal_i[evt_line_i]) code_d = ST_COALESCED;
    else                         code_d = ST_ACCEPTED;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_vld_o  <= 1'b0;
      stat_code_o <= ST_ACCEPTED;
    end else begin
      stat_vld_o <= fire;
      if (fire) stat_code_o <= code_d;
    end
  end

  a_r5_status_after_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> stat_vld_o);
  a_r8_no_status_without_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire |=> !stat_vld_o);
  a_r5_masked_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && mask_i[evt_line_i]) |=> (stat_code_o == ST_MASKED));
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch
  import irq_latch_pkg::*;
#(
  parameter int           N          = 8,
  parameter logic [N-1:0] MODE_WMASK = 8'hF8,
  localparam int          IW         = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          evt_vld_i,
  input  logic [IW-1:0] evt_line_i,
  input  logic          evt_level_i,
  input  logic [N-1:0]  mask_i,
  input  logic          ack_vld_i,
  input  logic [IW-1:0] ack_line_i,
  input  logic          mode_we_i,
  input  logic [N-1:0]  mode_wdata_i,
  input  logic          init_i,
  output logic [N-1:0]  req_o,
  output logic [N-1:0]  last_o,
  output logic [N-1:0]  mode_o,
  output logic          stat_vld_o,
  output logic [1:0]    stat_code_o
);
  logic [N-1:0] evt_hit, ack_hit, coal, mode_q;
  logic         ev_live, ack_live;
  stat_code_e   code;

  assign ev_live  = evt_vld_i & ~init_i;
  assign ack_live = ack_vld_i & ~init_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= '0;
    else if (mode_we_i) mode_q <= mode_wdata_i & MODE_WMASK;
  end

  irq_index_dec #(.N(N)) u_evt_dec (.en_i(ev_live),  .idx_i(evt_line_i), .hit_o(evt_hit));
  irq_index_dec #(.N(N)) u_ack_dec (.en_i(ack_live), .idx_i(ack_line_i), .hit_o(ack_hit));

  for (genvar g = 0; g < N; g++) begin : g_line
    irq_line_cell u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .evt_hit_i (evt_hit[g]),
      .level_i   (evt_level_i),
      .mode_i    (mode_q[g]),
      .ack_hit_i (ack_hit[g]),
      .init_i    (init_i),
      .req_o     (req_o[g]),
      .last_o    (last_o[g]),
      .coal_o    (coal[g])
    );
  end

  irq_stat_gen #(.N(N)) u_stat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_vld_i   (evt_vld_i),
    .evt_line_i  (evt_line_i),
    .init_i      (init_i),
    .mask_i      (mask_i),
    .coal_i      (coal),
    .stat_vld_o  (stat_vld_o),
    .stat_code_o (code)
  );

  assign mode_o      = mode_q;
  assign stat_code_o = code;

  a_r6_mode_write_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_we_i |=> (mode_o == ($past(mode_wdata_i) & MODE_WMASK)));
  a_r9_mode_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_we_i |=> $stable(mode_o));
  a_r7_ack_level_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_live && mode_q[ack_line_i] && !evt_vld_i) |=> $stable(req_o));
endmodule

// File: tb/irq_req_latch_tb.sv
module irq_req_latch_tb;
  localparam int N = 8;
  localparam logic [7:0] WM = 8'hF8;

  logic clk = 0, rst_n = 0;
  logic evt_v = 0, lvl = 0, ack_v = 0, mwe = 0, init = 0;
  logic [2:0] eline = 0, aline = 0;
  logic [7:0] mask = 0, mdata = 0;
  logic [7:0] req, last, mode;
  logic svld;
  logic [1:0] scode;

  int n_chk = 0, n_fail = 0;
  logic [7:0] m_req = 0, m_last = 0, m_mode = 0;
  logic e_vld = 0;
  logic [1:0] e_code = 2'b01;

  always #5 clk = ~clk;

  irq_req_latch u_dut (
    .clk_i(clk), .rst_ni(rst_n), .evt_vld_i(evt_v), .evt_line_i(eline),
    .evt_level_i(lvl), .mask_i(mask), .ack_vld_i(ack_v), .ack_line_i(aline),
    .mode_we_i(mwe), .mode_wdata_i(mdata), .init_i(init),
    .req_o(req), .last_o(last), .mode_o(mode),
    .stat_vld_o(svld), .stat_code_o(scode));

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Reference model, built from the requirement list
  function automatic void model(input logic ev, input int el, input logic lv, input logic [7:0] mk,
                                input logic ak, input int al, input logic we, input logic [7:0] wd,
                                input logic in);
    logic try_s;
    e_vld = 0;
    if (in) begin
      m_last = 0;
      m_req  = m_req & m_mode;
    end else begin
      if (ak && !m_mode[al]) m_req[al] = 0;
      if (ev) begin
        try_s  = lv && (m_mode[el] || !m_last[el]);
        e_vld  = 1;
        e_code = mk[el] ? 2'b11 : ((try_s && m_req[el]) ? 2'b00 : 2'b01);
        if (m_mode[el]) m_req[el] = lv;
        else if (try_s) m_req[el] = 1;
        m_last[el] = lv;
      end
    end
    if (we) m_mode = wd & WM;
  endfunction

  task automatic step(input string tag, input logic ev, input int el, input logic lv,
                      input logic [7:0] mk, input logic ak, input int al,
                      input logic we, input logic [7:0] wd, input logic in);
    @(negedge clk);
    evt_v = ev; eline = 3'(el); lvl = lv; mask = mk;
    ack_v = ak; aline = 3'(al); mwe = we; mdata = wd; init = in;
    model(ev, el, lv, mk, ak, al, we, wd, in);
    @(posedge clk); #1;
    chk(tag, "req", int'(req), int'(m_req));
    chk(tag, "last", int'(last), int'(m_last));
    chk(tag, "mode", int'(mode), int'(m_mode));
    chk(tag, "stat_vld", int'(svld), int'(e_vld));
    if (e_vld) chk(tag, "stat_code", int'(scode), int'(e_code));
    @(negedge clk);
    evt_v = 0; ack_v = 0; mwe = 0; init = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "req reset", int'(req), 0);
    chk("R1", "last reset", int'(last), 0);
    chk("R1", "mode reset", int'(mode), 0);
    chk("R1", "stat_vld reset", int'(svld), 0);
    @(negedge clk); rst_n = 1;

    // R6: mode write masked, lines 0..2 stay edge
    step("R6", 0,0,0, 8'h00, 0,0, 1, 8'hFF, 0);
    // R3: edge line 1 rises -> accepted
    step("R3", 1,1,1, 8'h00, 0,0, 0, 0, 0);
    // R3: high again without low -> no new set, status accepted (not a set attempt)
    step("R3", 1,1,1, 8'h00, 0,0, 0, 0, 0);
    // R4: low keeps request
    step("R4", 1,1,0, 8'h00, 0,0, 0, 0, 0);
    // R5: new edge finds bit set -> coalesced
    step("R5", 1,1,1, 8'h00, 0,0, 0, 0, 0);
    // R2: level line 4 follows
    step("R2", 1,4,1, 8'h00, 0,0, 0, 0, 0);
    step("R5", 1,4,1, 8'h00, 0,0, 0, 0, 0);
    // R7: ack on level line keeps, ack on edge clears
    step("R7", 0,0,0, 8'h00, 1,4, 0, 0, 0);
    step("R7", 0,0,0, 8'h00, 1,1, 0, 0, 0);
    step("R2", 1,4,0, 8'h00, 0,0, 0, 0, 0);
    // R10: masked event still captured, status masked
    step("R10", 1,0,1, 8'h01, 0,0, 0, 0, 0);
    // R7: ack and event same line same cycle
    step("R7", 1,0,1, 8'h00, 1,0, 0, 0, 0);
    // R9: mode write with event same cycle uses old mode (line 5 level)
    step("R9", 1,5,1, 8'h00, 0,0, 1, 8'h00, 0);
    step("R9", 1,5,0, 8'h00, 0,0, 0, 0, 0);
    // R8: init with pending edge and level requests, event ignored
    step("R8", 0,0,0, 8'h00, 0,0, 1, 8'hF8, 0);
    step("R8", 1,6,1, 8'h00, 0,0, 0, 0, 0);
    step("R8", 1,2,1, 8'h00, 0,0, 0, 0, 0);
    step("R8", 1,3,1, 8'h00, 1,2, 0, 0, 1);

    // random phase, all requirements
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] mk, wd;
      logic ev, ak, we, in;
      ev = ($urandom % 4) != 0;
      ak = ($urandom % 4) == 0;
      we = ($urandom % 20) == 0;
      in = ($urandom % 60) == 0;
      mk = 8'($urandom);
      wd = 8'($urandom);
      step("R10 random", ev, int'($urandom % 8), 1'($urandom), mk, ak, int'($urandom % 8), we, wd, in);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule